// File: doc/BRIEF.md
# SPI Register Readback Slave

This block is a serial slave that takes 24-bit command frames, most significant bit first, while an active-low select line is held low. Every frame carries a direction flag in bit 23 (1 asks for a readback), a 2-bit device address in bits 22:21, a 5-bit register selector in bits 20:16 and a 16-bit data field in bits 15:0. The block keeps a small register bank: six registers for each of four channels (output data, control, gain, offset, clear code and slew setting), a main control register and a supply-converter control register. A read-only status word comes in on a port.

A read command only picks a register. The value is captured when that frame ends and is shifted out during the next frame, whatever that next frame carries. A host therefore either chains reads, each frame bringing out the result of the one before, or ends with a no-operation frame to get the last value. The serial pins are sampled by the system clock through synchronizer stages, so the serial clock must be several times slower than the system clock.

Top module: `spi_rb_slave`

## Requirements
- R1: After reset, SDO is low, nothing is pending and every stored register reads back as 0x0000.
- R2: A complete frame with bit 23 = 0 and bits 22:21 equal to `dev_addr_i` writes bits 15:0 into the register picked by bits 20:16. Codes 0 to 23 and 25 to 26 are writable.
- R3: The selector map is: 0-3 data of channels A-D, 4-7 control, 8-11 gain, 12-15 offset, 16-19 clear code, 20-23 slew setting, 24 status, 25 main control, 26 converter control.
- R4: A complete read frame (bit 23 = 1, address match) captures the selected value. During the next frame, SDO carries 8 zero bits and then the 16-bit value, MSB first. SDO changes after rising SCLK edges, and the slave samples SDI on falling SCLK edges, with SCLK idling high.
- R5: Selector codes 27-31 read as 0x0000, and writes to them change nothing. The no-operation word 0x1CE000 leaves every register unchanged.
- R6: A frame whose bits 22:21 differ from `dev_addr_i` writes nothing and leaves the pending readback, both its value and its presence, as it was.
- R7: A frame with fewer or more than 24 falling SCLK edges between select low and select high is ignored: no write, and the pending readback is kept.
- R8: SDO is low while the select line is high, and it is low through a whole frame when nothing is pending. A complete matching frame that is not a read discards the pending value.
- R9: Code 24 returns the `status_i` value as it stood when the read frame completed. Writes to code 24 are ignored.
- R10: With device address 1, the frame 0xA80000 followed by any complete frame brings out the channel A gain register during the second frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which also samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_addr_i | input | 2 | Configured device address, compared with frame bits 22:21 |
| status_i | input | 16 | Live status word, returned by selector 24 |
| sclk_i | input | 1 | Serial clock, idles high |
| sync_n_i | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |

## Verification
The assertions assume that the serial pins change slowly compared with `clk`. Every SCLK phase, and every gap between a select edge and an SCLK edge, must last longer than the synchronizer latency, so that a commit, a frame start and a shift never fall in the same cycle. The bench holds each SCLK phase and each select setup and hold for eight system clocks, and it changes SDI and `status_i` only while SCLK is high or between frames. Within that timing it sends full frames, short frames, long frames, frames with a foreign address, and frames that chain reads back to back.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

   // Per-channel register kinds, in selector order (kind = code / channels)
   typedef enum int unsigned {
      KIND_DATA   = 0,
      KIND_CTRL   = 1,
      KIND_GAIN   = 2,
      KIND_OFFSET = 3,
      KIND_CLEAR  = 4,
      KIND_SLEW   = 5
   } chan_kind_e;

   localparam int NUM_KINDS = 6;

   // Device-wide registers placed directly after the per-channel block
   typedef enum int unsigned {
      XR_STATUS = 0,
      XR_MAIN   = 1,
      XR_DCDC   = 2
   } extra_reg_e;

   localparam int NUM_EXTRA = 3;

endpackage

// File: rtl/spi_rb_frontend.sv
module spi_rb_frontend #(
   parameter int FRAME_W     = 24,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_i,
   input  logic               sync_n_i,
   input  logic               sdi_i,
   output logic               in_frame_o,
   output logic               frame_start_o,
   output logic               shift_o,
   output logic               commit_o,
   output logic [FRAME_W-1:0] word_o,
   output logic [CNT_W-1:0]   fall_cnt_o
);

   localparam logic [2:0]       PIN_IDLE = 3'b110;
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

   logic [2:0]         pins;
   logic [1:0]         prev_q;
   logic [FRAME_W-1:0] shreg_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               sclk_fall;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign pins = {sclk_i, sync_n_i, sdi_i};
      end else begin : g_sync
         logic [2:0] stage_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < SYNC_STAGES; k++) stage_q[k] <= PIN_IDLE;
            end else begin
               stage_q[0] <= {sclk_i, sync_n_i, sdi_i};
               for (int k = 1; k < SYNC_STAGES; k++) stage_q[k] <= stage_q[k-1];
            end
         end
         assign pins = stage_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= PIN_IDLE[2:1];
      else        prev_q <= pins[2:1];
   end

   assign sclk_fall     = prev_q[1] & ~pins[2];
   assign shift_o       = ~prev_q[1] & pins[2];
   assign frame_start_o = prev_q[0] & ~pins[1];
   assign in_frame_o    = ~pins[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         shreg_q <= '0;
      end else if (frame_start_o) begin
         cnt_q   <= '0;
      end else if (sclk_fall && in_frame_o) begin
         shreg_q <= {shreg_q[FRAME_W-2:0], pins[0]};
         if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign commit_o   = ~prev_q[0] & pins[1] & (cnt_q == CNT_FULL);
   assign word_o     = shreg_q;
   assign fall_cnt_o = cnt_q;

endmodule

// File: rtl/spi_rb_regbank.sv
module spi_rb_regbank
   import spi_rb_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int SEL_W  = 5,
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [SEL_W-1:0]  wr_sel_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [SEL_W-1:0]  rd_sel_i,
   input  logic [DATA_W-1:0] status_i,
   output logic [DATA_W-1:0] rd_data_o
);

   localparam int               CH_REGS    = NUM_KINDS * NUM_CH;
   localparam logic [SEL_W-1:0] SEL_STATUS = SEL_W'(CH_REGS + int'(XR_STATUS));
   localparam logic [SEL_W-1:0] SEL_MAIN   = SEL_W'(CH_REGS + int'(XR_MAIN));
   localparam logic [SEL_W-1:0] SEL_DCDC   = SEL_W'(CH_REGS + int'(XR_DCDC));

   logic [DATA_W-1:0] chan_q [CH_REGS];
   logic [DATA_W-1:0] main_q;
   logic [DATA_W-1:0] dcdc_q;

   genvar k, c;
   generate
      for (k = 0; k < NUM_KINDS; k++) begin : g_kind
         for (c = 0; c < NUM_CH; c++) begin : g_ch
            localparam int IDX = k * NUM_CH + c;
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                                     q <= '0;
               else if (wr_en_i && wr_sel_i == SEL_W'(IDX))    q <= wr_data_i;
            end
            assign chan_q[IDX] = q;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_q <= '0;
         dcdc_q <= '0;
      end else if (wr_en_i) begin
         if (wr_sel_i == SEL_MAIN) main_q <= wr_data_i;
         if (wr_sel_i == SEL_DCDC) dcdc_q <= wr_data_i;
      end
   end

   always_comb begin
      rd_data_o = '0;
      if (rd_sel_i < SEL_W'(CH_REGS))  rd_data_o = chan_q[rd_sel_i];
      else if (rd_sel_i == SEL_STATUS) rd_data_o = status_i;
      else if (rd_sel_i == SEL_MAIN)   rd_data_o = main_q;
      else if (rd_sel_i == SEL_DCDC)   rd_data_o = dcdc_q;
   end

endmodule

// File: rtl/spi_rb_txpath.sv
module spi_rb_txpath #(
   parameter int FRAME_W = 24,
   parameter int DATA_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              drop_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              in_frame_i,
   input  logic              frame_start_i,
   input  logic              shift_i,
   output logic              pend_valid_o,
   output logic [DATA_W-1:0] pend_data_o,
   output logic              sdo_o
);

   localparam int PAD_W = FRAME_W - DATA_W;

   logic [FRAME_W-1:0] out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_valid_o <= 1'b0;
         pend_data_o  <= '0;
      end else if (load_i) begin
         pend_valid_o <= 1'b1;
         pend_data_o  <= data_i;
      end else if (drop_i) begin
         pend_valid_o <= 1'b0;
         pend_data_o  <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             out_q <= '0;
      else if (!in_frame_i)   out_q <= '0;
      else if (frame_start_i) out_q <= pend_valid_o ? {{PAD_W{1'b0}}, pend_data_o} : '0;
      else if (shift_i)       out_q <= {out_q[FRAME_W-2:0], 1'b0};
   end

   assign sdo_o = out_q[FRAME_W-1];

endmodule

// File: rtl/spi_rb_slave.sv
module spi_rb_slave
   import spi_rb_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 2,
   parameter int SEL_W       = 5,
   parameter int FRAME_W     = 24,
   parameter int NUM_CH      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] dev_addr_i,
   input  logic [DATA_W-1:0] status_i,
   input  logic              sclk_i,
   input  logic              sync_n_i,
   input  logic              sdi_i,
   output logic              sdo_o
);

   localparam int CNT_W    = $clog2(FRAME_W + 2);
   localparam int RSV_BASE = NUM_KINDS * NUM_CH + NUM_EXTRA;
   localparam int ADDR_HI  = FRAME_W - 2;
   localparam int SEL_HI   = ADDR_HI - ADDR_W;

   generate
      if (FRAME_W != 1 + ADDR_W + SEL_W + DATA_W) begin : g_bad_frame
         $error("frame width must equal flag + address + selector + data");
      end
      if (NUM_CH < 1 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
         $error("channel count must be a power of two");
      end
      if (RSV_BASE > (1 << SEL_W)) begin : g_bad_sel
         $error("selector too narrow for the register bank");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("synchronizer depth cannot be negative");
      end
   endgenerate

   logic               in_frame;
   logic               frame_start;
   logic               tx_shift;
   logic               frame_commit;
   logic [FRAME_W-1:0] frame_word;
   logic [CNT_W-1:0]   bit_cnt;
   logic               addr_hit;
   logic               is_read;
   logic [SEL_W-1:0]   frame_sel;
   logic [DATA_W-1:0]  rd_data;
   logic               pend_valid;
   logic [DATA_W-1:0]  pend_data;

   spi_rb_frontend #(
      .FRAME_W    (FRAME_W),
      .SYNC_STAGES(SYNC_STAGES),
      .CNT_W      (CNT_W)
   ) u_front (
      .clk          (clk),
      .rst_n        (rst_n),
      .sclk_i       (sclk_i),
      .sync_n_i     (sync_n_i),
      .sdi_i        (sdi_i),
      .in_frame_o   (in_frame),
      .frame_start_o(frame_start),
      .shift_o      (tx_shift),
      .commit_o     (frame_commit),
      .word_o       (frame_word),
      .fall_cnt_o   (bit_cnt)
   );

   assign is_read   = frame_word[FRAME_W-1];
   assign addr_hit  = frame_word[ADDR_HI -: ADDR_W] == dev_addr_i;
   assign frame_sel = frame_word[SEL_HI -: SEL_W];

   spi_rb_regbank #(
      .DATA_W(DATA_W),
      .SEL_W (SEL_W),
      .NUM_CH(NUM_CH)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (frame_commit & addr_hit & ~is_read),
      .wr_sel_i (frame_sel),
      .wr_data_i(frame_word[DATA_W-1:0]),
      .rd_sel_i (frame_sel),
      .status_i (status_i),
      .rd_data_o(rd_data)
   );

   spi_rb_txpath #(
      .FRAME_W(FRAME_W),
      .DATA_W (DATA_W)
   ) u_tx (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (frame_commit & addr_hit & is_read),
      .drop_i       (frame_commit & addr_hit & ~is_read),
      .data_i       (rd_data),
      .in_frame_i   (in_frame),
      .frame_start_i(frame_start),
      .shift_i      (tx_shift),
      .pend_valid_o (pend_valid),
      .pend_data_o  (pend_data),
      .sdo_o        (sdo_o)
   );

endmodule

// File: rtl/spi_rb_checker.sv
module spi_rb_checker #(
   parameter int FRAME_W  = 24,
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 2,
   parameter int SEL_W    = 5,
   parameter int CNT_W    = 5,
   parameter int RSV_BASE = 27
) (
   input logic               clk,
   input logic               rst_n,
   input logic               commit,
   input logic [FRAME_W-1:0] word,
   input logic [ADDR_W-1:0]  dev_addr,
   input logic               in_frame,
   input logic               pend_valid,
   input logic [DATA_W-1:0]  pend_data,
   input logic               sdo,
   input logic [CNT_W-1:0]   fall_cnt
);

   logic             w_read;
   logic             w_hit;
   logic [SEL_W-1:0] w_sel;

   assign w_read = word[FRAME_W-1];
   assign w_hit  = word[FRAME_W-2 -: ADDR_W] == dev_addr;
   assign w_sel  = word[FRAME_W-2-ADDR_W -: SEL_W];

   assert_read_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
      commit && w_read && w_hit |=> pend_valid);

   assert_lead_zeros_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_frame && $past(in_frame) && fall_cnt < CNT_W'(8) |-> !sdo);

   assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      commit && w_read && w_hit && w_sel >= SEL_W'(RSV_BASE) |=> pend_data == '0);

   assert_foreign_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      commit && !w_hit |=> $stable(pend_valid) && $stable(pend_data));

   assert_no_commit_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(pend_valid) && $stable(pend_data));

   assert_write_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      commit && !w_read && w_hit |=> !pend_valid);

   assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_frame && $past(!in_frame) |-> !sdo);

endmodule

bind spi_rb_slave spi_rb_checker #(
   .FRAME_W (FRAME_W),
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .SEL_W   (SEL_W),
   .CNT_W   (CNT_W),
   .RSV_BASE(RSV_BASE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .commit    (frame_commit),
   .word      (frame_word),
   .dev_addr  (dev_addr_i),
   .in_frame  (in_frame),
   .pend_valid(pend_valid),
   .pend_data (pend_data),
   .sdo       (sdo_o),
   .fall_cnt  (bit_cnt)
);

// File: tb/tb_spi_rb_slave.sv
module tb_spi_rb_slave;

   localparam int HALF   = 8;
   localparam int WD_MAX = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  dev = 2'b01;
   logic [15:0] status = 16'hBEEF;
   logic        sclk = 1'b1;
   logic        sync_n = 1'b1;
   logic        sdi = 1'b0;
   logic        sdo;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   int idle = 0;
   bit done = 0;

   // behavioural reference: flat register image and pending readback
   logic [15:0] mregs [32];
   bit          mvalid = 0;
   logic [15:0] mpend = '0;

   always #10 clk = ~clk;

   spi_rb_slave dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .dev_addr_i(dev),
      .status_i  (status),
      .sclk_i    (sclk),
      .sync_n_i  (sync_n),
      .sdi_i     (sdi),
      .sdo_o     (sdo)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [23:0] act, input logic [23:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [15:0] model_read(input int s);
      if (s == 24) return status;
      if (s <= 26) return mregs[s];
      return 16'h0000;
   endfunction

   function automatic logic [23:0] rd(input int s);
      return {1'b1, dev, 5'(s), 16'h0000};
   endfunction

   function automatic logic [23:0] wr(input int s, input logic [15:0] d);
      return {1'b0, dev, 5'(s), d};
   endfunction

   // one frame of n falling edges; compares SDO against the reference for full frames
   task automatic send(input logic [23:0] w, input int n, input string tag);
      logic [23:0] exp;
      logic [23:0] got;
      int sel;
      exp = mvalid ? {8'h00, mpend} : 24'h0;
      got = '0;
      sync_n = 1'b0;
      wait_clk(HALF);
      for (int i = 0; i < n; i++) begin
         sdi = (i < 24) ? w[23-i] : 1'b0;
         wait_clk(HALF);
         if (i < 24) got[23-i] = sdo;
         sclk = 1'b0;
         wait_clk(HALF);
         sclk = 1'b1;
      end
      wait_clk(HALF);
      sync_n = 1'b1;
      wait_clk(2 * HALF);
      if (n == 24) begin
         check(got === exp, tag, "sdo frame", got, exp);
         sel = int'(w[20:16]);
         if (w[22:21] == dev) begin
            if (w[23]) begin
               mpend  = model_read(sel);
               mvalid = 1;
            end else begin
               if (sel < 24 || sel == 25 || sel == 26) mregs[sel] = w[15:0];
               mvalid = 0;
            end
         end
      end
   endtask

   // R8: with select high for a while, SDO must stay low on every clock
   always @(negedge clk) begin
      if (!rst_n || !sync_n) idle = 0;
      else idle++;
      if (rst_n && idle > 6 && !done) check(sdo === 1'b0, "R8", "idle sdo", 24'(sdo), 24'h0);
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles == WD_MAX && !done) begin
         done = 1;
         bad++;
         total++;
         $display("FAIL R1 watchdog: actual=%0d cycles expected below %0d", cycles, WD_MAX);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int s = 0; s < 32; s++) mregs[s] = 16'h0000;
      wait_clk(5);
      check(sdo === 1'b0, "R1", "sdo in reset", 24'(sdo), 24'h0);
      rst_n = 1'b1;
      wait_clk(10);
      check(sdo === 1'b0, "R1", "sdo after reset", 24'(sdo), 24'h0);

      // R1: reset values via readback (first frame has nothing pending: R4, R8)
      send(rd(0), 24, "R1");
      send(rd(13), 24, "R1");
      send(rd(25), 24, "R1");
      send(rd(20), 24, "R1");

      // R2: fill every writable code with a distinct value
      for (int s = 0; s < 27; s++)
         if (s != 24) send(wr(s, 16'(s * 1234 + 777)), 24, "R2");

      // R3/R5/R9: chained reads of all 32 codes, each frame shows the previous one
      for (int s = 0; s < 32; s++) send(rd(s), 24, (s >= 27) ? "R5" : "R3");
      send(wr(28, 16'h0000), 24, "R5");

      // R9: write to status ignored, snapshot taken at commit
      send(wr(24, 16'h1234), 24, "R9");
      send(rd(24), 24, "R9");
      status = 16'h5A5A;
      send(wr(28, 16'h0000), 24, "R9");
      send(rd(24), 24, "R9");
      send(wr(28, 16'h0000), 24, "R9");

      // R10: literal read of channel A gain, flushed by the no-op word
      send(24'hA80000, 24, "R10");
      check(mpend === 16'(8 * 1234 + 777), "R10", "gain A captured", 24'(mpend), 24'(16'(8 * 1234 + 777)));
      send(24'h1CE000, 24, "R10");
      // R6: the no-op carries address 0, foreign here, so the value replays
      send(24'h1CE000, 24, "R6");
      send(wr(28, 16'h0000), 24, "R8");
      send(wr(28, 16'h0000), 24, "R8");

      // R5: no-op at a matching address changes no register
      dev = 2'b00;
      send(24'h1CE000, 24, "R5");
      dev = 2'b01;
      send(rd(0), 24, "R5");
      send(rd(26), 24, "R5");
      send(rd(23), 24, "R5");
      send(wr(28, 16'h0000), 24, "R5");

      // R6: foreign write and foreign read leave registers and pending alone
      send({1'b0, 2'b10, 5'd0, 16'hDEAD}, 24, "R6");
      send(rd(0), 24, "R6");
      send({1'b1, 2'b11, 5'd5, 16'h0000}, 24, "R6");
      send(wr(28, 16'h0000), 24, "R6");

      // R7: short and long frames are dropped
      send(rd(9), 24, "R7");
      send(wr(1, 16'hFFFF), 23, "R7");
      send(wr(1, 16'hEEEE), 25, "R7");
      send(wr(28, 16'h0000), 24, "R7");
      send(rd(1), 24, "R7");
      send(wr(28, 16'h0000), 24, "R7");

      wait_clk(20);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule